// File: doc/BRIEF.md
# TDMA Communication Cycle Sequencer

This block produces the repeating timeline of a time-triggered bus controller. Every step is paced by a macrotick enable. A cycle runs through four phases that never change order: a static segment made of equal static slots, a dynamic segment, a symbol window and an idle period. The symbol window may be configured to zero macroticks, and the phase is then skipped. The idle period takes all the macroticks of the configured cycle length that the first three phases leave over, and it clears the slot number.

The sequencer keeps a cycle number. The first cycle after the start state carries number 1. At the end of each cycle the number steps up by one and a one-clock cycle-start strobe goes to the media access logic. When the cycle that ends carries the configured maximum, the sequencer returns to its start state and then starts again at 1. A cycle normally ends when its idle timer runs out. An external cycle-end strobe seen during the idle period ends the cycle at once. All lengths and the maximum are static configuration inputs, held stable between resets, and the nodes are taken to be already synchronized.

Top module: `tdma_cycle_sequencer`

## Requirements
- R1: A synchronous active-high reset puts the block in its start state. In that state phase_o = 3, active_o = 0, cycle_o = 0, slot_o = 0 and cyc_start_o = 0.
- R2: In the start state, a clock with mt_en_i = 1, run_i = 1 and max_cycle_i >= 1 begins a cycle. After that edge cycle_o = 1, phase_o = 0, slot_o = 1 and cyc_start_o = 1. If run_i = 0 or max_cycle_i = 0, the block stays in the start state. run_i is read only in the start state.
- R3: phase_o encodes 0 static, 1 dynamic, 2 symbol window and 3 idle. The phases follow that order and last static_slots_i*slot_len_i, dyn_len_i and sym_len_i macroticks. The idle phase lasts cycle_len_i minus the sum of those three lengths, so a cycle spans exactly cycle_len_i macroticks.
- R4: When sym_len_i = 0, the dynamic segment is followed directly by the idle phase, and phase_o never shows 2.
- R5: slot_o is 1 at cycle start and rises by one after every slot_len_i macroticks of the static segment, up to static_slots_i. It holds that value through the dynamic and symbol phases and is 0 throughout the idle phase.
- R6: When a cycle ends with cycle_o below max_cycle_i, the next cycle starts on the same edge with cycle_o one higher and cyc_start_o high for exactly one clock.
- R7: When a cycle ends with cycle_o equal to max_cycle_i, the block returns to the start state with cycle_o = 0 and gives no strobe. It restarts at 1 under the rule of R2.
- R8: cyc_end_i = 1 during the idle phase ends the cycle on that clock, whether or not mt_en_i is set. In any other phase cyc_end_i has no effect.
- R9: All timers advance only on clocks with mt_en_i = 1. With mt_en_i = 0 and no cycle-end strobe during idle, every output holds its value.
- R10: cyc_start_o is high only while cycle_o lies between 1 and max_cycle_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mt_en_i | input | 1 | Macrotick enable; advances all timers |
| run_i | input | 1 | Permits leaving the start state |
| cyc_end_i | input | 1 | Ends the cycle early during the idle phase |
| static_slots_i | input | SLOT_W | Number of static slots, at least 1 |
| slot_len_i | input | MT_W | Macroticks per static slot, at least 1 |
| dyn_len_i | input | MT_W | Dynamic segment length in macroticks, at least 1 |
| sym_len_i | input | MT_W | Symbol window length in macroticks, may be 0 |
| cycle_len_i | input | MT_W | Total cycle length; leaves at least 1 idle macrotick |
| max_cycle_i | input | CYC_W | Highest cycle number before the sequence restarts |
| phase_o | output | 2 | Current phase code |
| active_o | output | 1 | High outside the start state |
| cycle_o | output | CYC_W | Current cycle number, 0 in the start state |
| slot_o | output | SLOT_W | Current static slot number |
| cyc_start_o | output | 1 | One-clock strobe when a cycle begins |

## Verification
Each output comes from a register, so a result is due on the same rising edge that samples the mt_en_i or cyc_end_i stimulus, with no further delay. The bench changes inputs on the falling edge, waits one rising edge and compares on the next falling edge. It keeps a macrotick position within the cycle and works out the expected phase, slot, cycle number and strobe from the configured lengths. Sweeps cover several configurations, one of them with a zero symbol window and one with a maximum of zero, and a run where the macrotick enable comes only on some clocks.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

    typedef enum logic [2:0] {
        ST_INIT   = 3'd0,
        ST_STATIC = 3'd1,
        ST_DYN    = 3'd2,
        ST_SYM    = 3'd3,
        ST_IDLE   = 3'd4
    } seq_state_e;

    localparam logic [1:0] PH_STATIC = 2'd0;
    localparam logic [1:0] PH_DYN    = 2'd1;
    localparam logic [1:0] PH_SYM    = 2'd2;
    localparam logic [1:0] PH_IDLE   = 2'd3;

endpackage

// File: rtl/tcs_len_calc.sv
module tcs_len_calc #(
    parameter int MT_W   = 16,
    parameter int SLOT_W = 8
) (
    input  logic [SLOT_W-1:0] static_slots_i,
    input  logic [MT_W-1:0]   slot_len_i,
    input  logic [MT_W-1:0]   dyn_len_i,
    input  logic [MT_W-1:0]   sym_len_i,
    input  logic [MT_W-1:0]   cycle_len_i,
    output logic [MT_W-1:0]   idle_len_o
);

    logic [MT_W-1:0] static_len;
    logic [MT_W-1:0] busy_len;

    // Idle time is whatever the cycle leaves after the three leading phases.
    always_comb begin
        static_len = MT_W'(static_slots_i) * slot_len_i;
        busy_len   = static_len + dyn_len_i + sym_len_i;
        idle_len_o = cycle_len_i - busy_len;
    end

endmodule

// File: rtl/tcs_cycle_ctr.sv
module tcs_cycle_ctr #(
    parameter int CYC_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             begin_evt_i,
    input  logic             end_evt_i,
    input  logic [CYC_W-1:0] max_cycle_i,
    output logic [CYC_W-1:0] cnt_o,
    output logic             start_o,
    output logic             at_max_o
);

    localparam logic [CYC_W-1:0] ONE_C = CYC_W'(1);

    typedef struct packed {
        logic [CYC_W-1:0] cnt;
        logic             start;
    } cregs_t;

    cregs_t cq, cd;

    assign at_max_o = (cq.cnt >= max_cycle_i);

    always_comb begin
        cd       = cq;
        cd.start = 1'b0;
        if (begin_evt_i) begin
            cd.cnt   = ONE_C;
            cd.start = 1'b1;
        end else if (end_evt_i) begin
            if (at_max_o) begin
                cd.cnt = '0;
            end else begin
                cd.cnt   = cq.cnt + ONE_C;
                cd.start = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cq <= '0;
        end else begin
            cq <= cd;
        end
    end

    assign cnt_o   = cq.cnt;
    assign start_o = cq.start;

    // R10: a strobe only accompanies a cycle number inside 1..max
    assert_start_in_range_R10: assert property (@(posedge clk) disable iff (rst)
        cq.start |-> (cq.cnt != '0) && (cq.cnt <= max_cycle_i));

    // R6: a strobe following a running cycle carries the next number
    assert_step_by_one_R6: assert property (@(posedge clk) disable iff (rst)
        (cq.start && ($past(cq.cnt) != '0)) |-> (cq.cnt == CYC_W'($past(cq.cnt) + ONE_C)));

    // R7: the number changes without a strobe only when it wraps to zero
    assert_silent_change_is_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (!cq.start && (cq.cnt != $past(cq.cnt))) |-> (cq.cnt == '0));

endmodule

// File: rtl/tcs_phase_ctrl.sv
module tcs_phase_ctrl
    import tcs_pkg::*;
#(
    parameter int MT_W   = 16,
    parameter int SLOT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mt_en_i,
    input  logic              run_i,
    input  logic              cyc_end_i,
    input  logic [SLOT_W-1:0] static_slots_i,
    input  logic [MT_W-1:0]   slot_len_i,
    input  logic [MT_W-1:0]   dyn_len_i,
    input  logic [MT_W-1:0]   sym_len_i,
    input  logic [MT_W-1:0]   idle_len_i,
    input  logic              max_nz_i,
    input  logic              at_max_i,
    output seq_state_e        state_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic              begin_evt_o,
    output logic              end_evt_o
);

    localparam logic [MT_W-1:0]   ONE_MT = MT_W'(1);
    localparam logic [SLOT_W-1:0] ONE_SL = SLOT_W'(1);

    typedef struct packed {
        seq_state_e        st;
        logic [MT_W-1:0]   tick;
        logic [SLOT_W-1:0] slot;
    } regs_t;

    regs_t rq, rd;

    logic slot_done, dyn_done, sym_done, idle_done;

    always_comb begin
        slot_done = (rq.tick == slot_len_i - ONE_MT);
        dyn_done  = (rq.tick == dyn_len_i - ONE_MT);
        sym_done  = (rq.tick == sym_len_i - ONE_MT);
        idle_done = (rq.tick == idle_len_i - ONE_MT);
    end

    always_comb begin
        rd          = rq;
        begin_evt_o = 1'b0;
        end_evt_o   = 1'b0;
        unique case (rq.st)
            ST_INIT: begin
                if (mt_en_i && run_i && max_nz_i) begin
                    begin_evt_o = 1'b1;
                    rd.st       = ST_STATIC;
                    rd.tick     = '0;
                    rd.slot     = ONE_SL;
                end
            end
            ST_STATIC: begin
                if (mt_en_i) begin
                    if (slot_done) begin
                        rd.tick = '0;
                        if (rq.slot == static_slots_i) begin
                            rd.st = ST_DYN;
                        end else begin
                            rd.slot = rq.slot + ONE_SL;
                        end
                    end else begin
                        rd.tick = rq.tick + ONE_MT;
                    end
                end
            end
            ST_DYN: begin
                if (mt_en_i) begin
                    if (dyn_done) begin
                        rd.tick = '0;
                        if (sym_len_i == '0) begin
                            rd.st   = ST_IDLE;
                            rd.slot = '0;
                        end else begin
                            rd.st = ST_SYM;
                        end
                    end else begin
                        rd.tick = rq.tick + ONE_MT;
                    end
                end
            end
            ST_SYM: begin
                if (mt_en_i) begin
                    if (sym_done) begin
                        rd.tick = '0;
                        rd.st   = ST_IDLE;
                        rd.slot = '0;
                    end else begin
                        rd.tick = rq.tick + ONE_MT;
                    end
                end
            end
            ST_IDLE: begin
                if (cyc_end_i || (mt_en_i && idle_done)) begin
                    end_evt_o = 1'b1;
                    rd.tick   = '0;
                    if (at_max_i) begin
                        rd.st   = ST_INIT;
                        rd.slot = '0;
                    end else begin
                        rd.st   = ST_STATIC;
                        rd.slot = ONE_SL;
                    end
                end else if (mt_en_i) begin
                    rd.tick = rq.tick + ONE_MT;
                end
            end
            default: begin
                rd = '{st: ST_INIT, tick: '0, slot: '0};
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rq <= '{st: ST_INIT, tick: '0, slot: '0};
        end else begin
            rq <= rd;
        end
    end

    assign state_o = rq.st;
    assign slot_o  = rq.slot;

    // R3: the static segment is always followed by the dynamic segment
    assert_static_then_dyn_R3: assert property (@(posedge clk) disable iff (rst)
        (($past(rq.st) == ST_STATIC) && (rq.st != ST_STATIC)) |-> (rq.st == ST_DYN));

    // R4: after the dynamic segment, a zero symbol window leads straight to idle
    assert_dyn_exit_R4: assert property (@(posedge clk) disable iff (rst)
        (($past(rq.st) == ST_DYN) && (rq.st != ST_DYN))
            |-> (rq.st == ((sym_len_i == '0) ? ST_IDLE : ST_SYM)));

    // R5: the slot number reads zero for the whole idle phase
    assert_idle_slot_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (rq.st == ST_IDLE) |-> (rq.slot == '0));

    // R3: leaving idle always means a new cycle or the start state
    assert_idle_exit_R3: assert property (@(posedge clk) disable iff (rst)
        (($past(rq.st) == ST_IDLE) && (rq.st != ST_IDLE))
            |-> ((rq.st == ST_STATIC) || (rq.st == ST_INIT)));

    // R9: no macrotick and no cycle-end strobe leaves every timer frozen
    assert_hold_without_tick_R9: assert property (@(posedge clk) disable iff (rst)
        (!mt_en_i && !cyc_end_i) |=> $stable(rq));

    // R8: a cycle-end strobe outside idle changes nothing
    assert_cyc_end_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (!mt_en_i && cyc_end_i && (rq.st != ST_IDLE)) |=> $stable(rq));

endmodule

// File: rtl/tdma_cycle_sequencer.sv
module tdma_cycle_sequencer
    import tcs_pkg::*;
#(
    parameter int MT_W   = 16,
    parameter int SLOT_W = 8,
    parameter int CYC_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mt_en_i,
    input  logic              run_i,
    input  logic              cyc_end_i,
    input  logic [SLOT_W-1:0] static_slots_i,
    input  logic [MT_W-1:0]   slot_len_i,
    input  logic [MT_W-1:0]   dyn_len_i,
    input  logic [MT_W-1:0]   sym_len_i,
    input  logic [MT_W-1:0]   cycle_len_i,
    input  logic [CYC_W-1:0]  max_cycle_i,
    output logic [1:0]        phase_o,
    output logic              active_o,
    output logic [CYC_W-1:0]  cycle_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic              cyc_start_o
);

    logic [MT_W-1:0] idle_len;
    seq_state_e      state;
    logic            begin_evt;
    logic            end_evt;
    logic            at_max;
    logic            max_nz;

    assign max_nz = (max_cycle_i != '0);

    tcs_len_calc #(.MT_W(MT_W), .SLOT_W(SLOT_W)) u_len (
        .static_slots_i (static_slots_i),
        .slot_len_i     (slot_len_i),
        .dyn_len_i      (dyn_len_i),
        .sym_len_i      (sym_len_i),
        .cycle_len_i    (cycle_len_i),
        .idle_len_o     (idle_len)
    );

    tcs_phase_ctrl #(.MT_W(MT_W), .SLOT_W(SLOT_W)) u_phase (
        .clk            (clk),
        .rst            (rst),
        .mt_en_i        (mt_en_i),
        .run_i          (run_i),
        .cyc_end_i      (cyc_end_i),
        .static_slots_i (static_slots_i),
        .slot_len_i     (slot_len_i),
        .dyn_len_i      (dyn_len_i),
        .sym_len_i      (sym_len_i),
        .idle_len_i     (idle_len),
        .max_nz_i       (max_nz),
        .at_max_i       (at_max),
        .state_o        (state),
        .slot_o         (slot_o),
        .begin_evt_o    (begin_evt),
        .end_evt_o      (end_evt)
    );

    tcs_cycle_ctr #(.CYC_W(CYC_W)) u_cycle (
        .clk         (clk),
        .rst         (rst),
        .begin_evt_i (begin_evt),
        .end_evt_i   (end_evt),
        .max_cycle_i (max_cycle_i),
        .cnt_o       (cycle_o),
        .start_o     (cyc_start_o),
        .at_max_o    (at_max)
    );

    always_comb begin
        unique case (state)
            ST_STATIC: phase_o = PH_STATIC;
            ST_DYN:    phase_o = PH_DYN;
            ST_SYM:    phase_o = PH_SYM;
            default:   phase_o = PH_IDLE;
        endcase
        active_o = (state != ST_INIT);
    end

    // R2: the cycle number is nonzero exactly while the sequencer is active
    assert_active_has_cycle_R2: assert property (@(posedge clk) disable iff (rst)
        active_o == (cycle_o != '0));

    // R1: the start state raises no strobe
    assert_no_strobe_in_start_R1: assert property (@(posedge clk) disable iff (rst)
        !active_o |-> !cyc_start_o);

endmodule

// File: tb/tb_tdma_cycle_sequencer.sv
module tb_tdma_cycle_sequencer;

    localparam int MT_W   = 16;
    localparam int SLOT_W = 8;
    localparam int CYC_W  = 6;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst = 1'b1;
    logic mt_en = 1'b0;
    logic run = 1'b0;
    logic cyc_end = 1'b0;

    int c_s = 2, c_l = 3, c_d = 4, c_y = 2, c_c = 16, c_m = 3;

    logic [1:0]        phase;
    logic              active;
    logic [CYC_W-1:0]  cycle;
    logic [SLOT_W-1:0] slot;
    logic              cstart;

    tdma_cycle_sequencer #(.MT_W(MT_W), .SLOT_W(SLOT_W), .CYC_W(CYC_W)) dut (
        .clk            (clk),
        .rst            (rst),
        .mt_en_i        (mt_en),
        .run_i          (run),
        .cyc_end_i      (cyc_end),
        .static_slots_i (SLOT_W'(c_s)),
        .slot_len_i     (MT_W'(c_l)),
        .dyn_len_i      (MT_W'(c_d)),
        .sym_len_i      (MT_W'(c_y)),
        .cycle_len_i    (MT_W'(c_c)),
        .max_cycle_i    (CYC_W'(c_m)),
        .phase_o        (phase),
        .active_o       (active),
        .cycle_o        (cycle),
        .slot_o         (slot),
        .cyc_start_o    (cstart)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    // reference model state
    bit m_init = 1;
    int m_cyc = 0;
    int m_p = 0;
    bit ex_start = 0;

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s got %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic int busy_len();
        return c_s * c_l + c_d + c_y;
    endfunction

    task automatic compare(input string ctx);
        int eph, esl;
        if (m_init) begin
            eph = 3; esl = 0;
        end else if (m_p < c_s * c_l) begin
            eph = 0; esl = m_p / c_l + 1;
        end else if (m_p < c_s * c_l + c_d) begin
            eph = 1; esl = c_s;
        end else if (m_p < busy_len()) begin
            eph = 2; esl = c_s;
        end else begin
            eph = 3; esl = 0;
        end
        chk({ctx, " R3 phase"}, int'(phase), eph);
        chk({ctx, " R5 slot"}, int'(slot), esl);
        chk({ctx, " R6 R7 cycle"}, int'(cycle), m_cyc);
        chk({ctx, " R10 strobe"}, int'(cstart), int'(ex_start));
        chk({ctx, " R2 active"}, int'(active), int'(!m_init));
    endtask

    task automatic end_cycle();
        if (m_cyc < c_m) begin
            m_cyc++;
            m_p = 0;
            ex_start = 1;
        end else begin
            m_init = 1;
            m_cyc = 0;
            m_p = 0;
        end
    endtask

    task automatic step(input logic mt, input logic ce, input string ctx);
        mt_en = mt;
        cyc_end = ce;
        @(posedge clk);
        @(negedge clk);
        mt_en = 1'b0;
        cyc_end = 1'b0;
        ex_start = 0;
        if (m_init) begin
            if (mt && run && c_m >= 1) begin
                m_init = 0; m_cyc = 1; m_p = 0; ex_start = 1;
            end
        end else if (ce && (m_p >= busy_len())) begin
            end_cycle();
        end else if (mt) begin
            m_p++;
            if (m_p == c_c) end_cycle();
        end
        compare(ctx);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        mt_en = 1'b0;
        cyc_end = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 reset phase", int'(phase), 3);
        chk("R1 reset active", int'(active), 0);
        chk("R1 reset cycle", int'(cycle), 0);
        chk("R1 reset slot", int'(slot), 0);
        chk("R1 reset strobe", int'(cstart), 0);
        rst = 1'b0;
        m_init = 1; m_cyc = 0; m_p = 0; ex_start = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL R3 watchdog got hung expected finish");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        // Configuration A: symbol window present, max 3
        c_s = 2; c_l = 3; c_d = 4; c_y = 2; c_c = 16; c_m = 3;
        run = 1'b1;
        do_reset();
        for (int i = 0; i < 2 * (c_m * c_c + 1) + 7; i++) step(1'b1, 1'b0, "R6 R7 sweepA");
        // sparse macroticks
        for (int i = 0; i < 90; i++) step((i % 3) != 0, 1'b0, "R9 sparse");
        repeat (5) step(1'b0, 1'b0, "R9 hold");
        // early end from idle
        while (m_init || (m_p < busy_len())) step(1'b1, 1'b0, "R8 seek idle");
        step(1'b0, 1'b1, "R8 early end");
        // strobe ignored in static and dynamic
        while (m_init || (m_p >= c_s * c_l)) step(1'b1, 1'b0, "R8 seek static");
        step(1'b0, 1'b1, "R8 ignored static");
        while (m_init || (m_p < c_s * c_l) || (m_p >= c_s * c_l + c_d)) step(1'b1, 1'b0, "R8 seek dyn");
        step(1'b0, 1'b1, "R8 ignored dyn");
        // strobe with macrotick in idle
        while (m_init || (m_p < busy_len())) step(1'b1, 1'b0, "R8 seek idle");
        step(1'b1, 1'b1, "R8 end with tick");
        // run low keeps start state after wrap
        run = 1'b0;
        while (!m_init) step(1'b1, 1'b0, "R7 to start");
        repeat (10) step(1'b1, 1'b0, "R2 run low");
        run = 1'b1;
        repeat (20) step(1'b1, 1'b0, "R2 restart");

        // Configuration B: zero symbol window, one-macrotick slots
        c_s = 3; c_l = 1; c_d = 2; c_y = 0; c_c = 9; c_m = 2;
        do_reset();
        for (int i = 0; i < 3 * (c_m * c_c + 1); i++) step(1'b1, 1'b0, "R4 sweepB");

        // Configuration C: maximum of zero never leaves the start state
        c_m = 0;
        do_reset();
        repeat (20) step(1'b1, 1'b0, "R2 max zero");

        // Configuration D: single slot, max 1
        c_s = 1; c_l = 2; c_d = 1; c_y = 1; c_c = 6; c_m = 1;
        do_reset();
        for (int i = 0; i < 4 * (c_c + 1); i++) step(1'b1, 1'b0, "R7 sweepD");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule